// File: doc/BRIEF.md
# Split Scan Chain Test Sequencer

This block drives the control lines of a full-scan chain that has been split into two sub-chains. One sub-chain holds the cells whose responses are mostly don't-care (the "quiet" sub-chain, DCS). The other holds the cells whose responses matter (the "care" sub-chain, CS). Each sub-chain has its own clock enable and its own serial input. The sequencer enables only one sub-chain in any shift or capture cycle. This staggers the switching and lowers the peak test power.

A test run starts with a one-cycle start strobe in test mode. At that moment the block latches the pattern-set mode, the pattern count, both sub-chain lengths and the filler bit value. It then steps through the schedule for the chosen mode:

- **Reuse mode.** The quiet sub-chain is loaded once and kept. Each later pattern shifts only the care sub-chain.
- **Reload mode.** Every pattern loads both sub-chains.
- **Double-capture mode.** The quiet sub-chain captures first. Its original stimulus is then shifted back in before the care sub-chain captures, so the second capture still sees intact stimulus. Stimulus for this re-shift comes from the pattern source, driven while `dcs_ce` and `scan_en` are high during phase 3.

A final flush with a constant filler word unloads the last care response. A phase code and a cycle counter are exposed so that the schedule length can be checked. Pattern storage, the scan cells and response compaction live outside the block.

Top module: `scan_split_seq`

## Requirements
- R1: While `test_mode` is 0, `scan_en` is 0 and both `dcs_ce` and `cs_ce` are 1, whatever the sequencer state.
- R2: While `test_mode` is 1, `dcs_ce` and `cs_ce` are never high together. `scan_en` is 1 in every shift cycle and 0 in every capture cycle. No two capture cycles are back to back.
- R3: With `mode_sel` = 0 (reuse), a run lasts (D+C+1) + (C+1)×(N−1) cycles. D and C are the quiet and care lengths, and N is the pattern count. The quiet sub-chain shifts D cycles in total, the care sub-chain shifts C×N cycles, and the care sub-chain captures N times.
- R4: With `mode_sel` = 1 (reload), a run lasts (D+C+1)×N cycles, with D×N quiet shifts, C×N care shifts and N care captures.
- R5: With `mode_sel[1]` = 1 (double capture), a run lasts (2D+C+2)×N + C cycles, with 2D×N quiet shifts, C×(N+1) care shifts, N quiet captures and N care captures.
- R6: In double-capture mode, each care capture is preceded, within the same pattern, by a quiet capture and then exactly D quiet-only shift cycles.
- R7: In reuse and reload modes the quiet sub-chain never captures.
- R8: In double-capture mode the last care capture is followed by C flush cycles. In each flush cycle `fill_en` is 1, only the care sub-chain shifts, and `fill_bit` equals the `fill_one` value latched at start.
- R9: A full load shifts the quiet sub-chain first, for D cycles, and then the care sub-chain, for C cycles. The first active cycle of every run is therefore a quiet shift.
- R10: `cyc_count` is cleared when a start is accepted and counts every scheduled cycle. In the cycle where `done` is high it equals the run length, and `phase` is 7.
- R11: `done` is high for exactly one cycle, after which `phase` returns to 0 and `busy` falls. The `phase` codes are: 0 idle, 1 full load, 2 care shift, 3 quiet re-shift, 4 care capture, 5 quiet capture, 6 flush, 7 done.
- R12: A start is accepted only when `phase` is 0 and `test_mode` is 1. A start while busy, or while `test_mode` is 0, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 selects test operation; 0 is normal operation |
| start | input | 1 | One-cycle run request |
| mode_sel | input | 2 | 0 reuse, 1 reload, 2 or 3 double capture |
| pat_count | input | CNT_W | Number of patterns, N (at least 1) |
| dcs_len | input | LEN_W | Quiet sub-chain length, D (at least 1) |
| cs_len | input | LEN_W | Care sub-chain length, C (at least 1) |
| fill_one | input | 1 | Filler bit value for the final flush |
| scan_en | output | 1 | 1 = shift, 0 = capture or functional |
| dcs_ce | output | 1 | Quiet sub-chain clock enable |
| cs_ce | output | 1 | Care sub-chain clock enable |
| fill_en | output | 1 | Care serial input takes the filler bit |
| fill_bit | output | 1 | Latched filler value |
| busy | output | 1 | A run is in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| phase | output | 3 | Current phase code |
| cyc_count | output | CYC_W | Scheduled cycles since start |

## Verification
The hardest situation to reach is a double-capture run with several patterns. There, the order "quiet capture, exactly D quiet-only shifts, care capture" must hold for every pattern, and the flush must follow only the final pattern. The stimulus sweeps every mode against every combination of small sub-chain lengths and pattern counts. It tracks, at the ports, the shift cycles seen between each quiet capture and the next care capture. It also fires a second start strobe in the middle of every run, to show that the schedule length does not change.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOAD   = 3'd1,
    PH_CSHIFT = 3'd2,
    PH_QSHIFT = 3'd3,
    PH_CCAP   = 3'd4,
    PH_QCAP   = 3'd5,
    PH_FLUSH  = 3'd6,
    PH_DONE   = 3'd7
  } phase_t;
endpackage

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [LEN_W-1:0] dcs_len,
  input  logic [LEN_W-1:0] cs_len,
  input  logic             fill_one,
  output phase_t           phase,
  output logic             half,
  output logic             accept,
  output logic             fill_q
);
  logic [LEN_W-1:0] rem, qlen, clen;
  logic [CNT_W-1:0] left;
  logic             multi_q, reuse_q;
  logic             last_step;

  assign accept    = (phase == PH_IDLE) && start && test_mode;
  assign last_step = (rem == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      half    <= 1'b0;
      rem     <= '0;
      qlen    <= '0;
      clen    <= '0;
      left    <= '0;
      multi_q <= 1'b0;
      reuse_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_LOAD;
          half    <= 1'b0;
          rem     <= dcs_len;
          qlen    <= dcs_len;
          clen    <= cs_len;
          left    <= pat_count;
          multi_q <= mode_sel[1];
          reuse_q <= (mode_sel == 2'd0);
          fill_q  <= fill_one;
        end
        PH_LOAD: begin
          if (!last_step) rem <= rem - LEN_W'(1);
          else if (!half) begin
            half <= 1'b1;
            rem  <= clen;
          end else phase <= multi_q ? PH_QCAP : PH_CCAP;
        end
        PH_QCAP: begin
          phase <= PH_QSHIFT;
          rem   <= qlen;
        end
        PH_QSHIFT: begin
          if (last_step) phase <= PH_CCAP;
          else rem <= rem - LEN_W'(1);
        end
        PH_CSHIFT: begin
          if (last_step) phase <= PH_CCAP;
          else rem <= rem - LEN_W'(1);
        end
        PH_CCAP: begin
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) begin
            phase <= multi_q ? PH_FLUSH : PH_DONE;
            rem   <= clen;
          end else if (reuse_q) begin
            phase <= PH_CSHIFT;
            rem   <= clen;
          end else begin
            phase <= PH_LOAD;
            half  <= 1'b0;
            rem   <= qlen;
          end
        end
        PH_FLUSH: begin
          if (last_step) phase <= PH_DONE;
          else rem <= rem - LEN_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sseq_decode.sv
module sseq_decode
  import sseq_pkg::*;
(
  input  phase_t phase,
  input  logic   half,
  input  logic   test_mode,
  output logic   scan_en,
  output logic   dcs_ce,
  output logic   cs_ce,
  output logic   fill_en
);
  logic se_t, q_t, c_t;

  always_comb begin
    se_t = 1'b0;
    q_t  = 1'b0;
    c_t  = 1'b0;
    case (phase)
      PH_LOAD:   begin se_t = 1'b1; q_t = !half; c_t = half; end
      PH_CSHIFT: begin se_t = 1'b1; c_t = 1'b1; end
      PH_QSHIFT: begin se_t = 1'b1; q_t = 1'b1; end
      PH_FLUSH:  begin se_t = 1'b1; c_t = 1'b1; end
      PH_CCAP:   c_t = 1'b1;
      PH_QCAP:   q_t = 1'b1;
      default:   ;
    endcase
  end

  assign scan_en = test_mode & se_t;
  assign dcs_ce  = !test_mode | q_t;
  assign cs_ce   = !test_mode | c_t;
  assign fill_en = test_mode & (phase == PH_FLUSH);
endmodule

// File: rtl/sseq_cycle_ctr.sv
module sseq_cycle_ctr #(
  parameter int CYC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count + CYC_W'(1);
  end
endmodule

// File: rtl/scan_split_seq.sv
module scan_split_seq
  import sseq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8,
  parameter int CYC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [LEN_W-1:0] dcs_len,
  input  logic [LEN_W-1:0] cs_len,
  input  logic             fill_one,
  output logic             scan_en,
  output logic             dcs_ce,
  output logic             cs_ce,
  output logic             fill_en,
  output logic             fill_bit,
  output logic             busy,
  output logic             done,
  output logic [2:0]       phase,
  output logic [CYC_W-1:0] cyc_count
);
  phase_t ph;
  logic   half, accept;

  sseq_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .mode_sel(mode_sel), .pat_count(pat_count), .dcs_len(dcs_len),
    .cs_len(cs_len), .fill_one(fill_one), .phase(ph), .half(half),
    .accept(accept), .fill_q(fill_bit)
  );

  sseq_decode u_dec (
    .phase(ph), .half(half), .test_mode(test_mode),
    .scan_en(scan_en), .dcs_ce(dcs_ce), .cs_ce(cs_ce), .fill_en(fill_en)
  );

  sseq_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .run((ph != PH_IDLE) && (ph != PH_DONE)), .count(cyc_count)
  );

  assign phase = ph;
  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_DONE);
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
  parameter int CYC_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic             scan_en,
  input logic             dcs_ce,
  input logic             cs_ce,
  input logic             busy,
  input logic             done,
  input logic [CYC_W-1:0] cyc_count
);
  // R1
  normal_mode_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (dcs_ce && cs_ce && !scan_en));

  // R2
  one_chain_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !(dcs_ce && cs_ce));

  // R2
  no_double_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !scan_en && (dcs_ce || cs_ce)) |=>
      !(test_mode && !scan_en && (dcs_ce || cs_ce)));

  // R11
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (cyc_count == $past(cyc_count) + CYC_W'(1)));
endmodule

bind scan_split_seq sseq_chk #(.CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
  .dcs_ce(dcs_ce), .cs_ce(cs_ce), .busy(busy), .done(done),
  .cyc_count(cyc_count)
);

// File: tb/scan_split_seq_tb.sv
module scan_split_seq_tb;
  localparam int LEN_W = 8;
  localparam int CNT_W = 8;
  localparam int CYC_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [CNT_W-1:0] pat_count = '0;
  logic [LEN_W-1:0] dcs_len = '0, cs_len = '0;
  logic fill_one = 1'b0;
  logic scan_en, dcs_ce, cs_ce, fill_en, fill_bit, busy, done;
  logic [2:0] phase;
  logic [CYC_W-1:0] cyc_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scan_split_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
    .mode_sel(mode_sel), .pat_count(pat_count), .dcs_len(dcs_len),
    .cs_len(cs_len), .fill_one(fill_one), .scan_en(scan_en),
    .dcs_ce(dcs_ce), .cs_ce(cs_ce), .fill_en(fill_en), .fill_bit(fill_bit),
    .busy(busy), .done(done), .phase(phase), .cyc_count(cyc_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int m, input int d, input int c, input int n, input bit fo);
    int cyc = 0, sd = 0, sc = 0, cc = 0, cd = 0, fl = 0, fbad = 0, both = 0;
    int ordbad = 0, rs = 0, guard = 0;
    bit await_c = 0, first_q = 0;
    int exp_tot, exp_sd, exp_sc, exp_cd, exp_fl;
    string tag;
    bit multi = (m >= 2);
    @(negedge clk);
    mode_sel = 2'(m); dcs_len = LEN_W'(d); cs_len = LEN_W'(c);
    pat_count = CNT_W'(n); fill_one = fo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 1000) begin
      guard++;
      cyc++;
      if (cyc == 1) first_q = scan_en && dcs_ce && !cs_ce;
      if (scan_en && dcs_ce) begin sd++; if (await_c) rs++; end
      if (scan_en && cs_ce) sc++;
      if (!scan_en && dcs_ce) begin cd++; await_c = 1; rs = 0; end
      if (!scan_en && cs_ce) begin
        cc++;
        if (multi && (!await_c || rs != d)) ordbad++;
        await_c = 0;
      end
      if (fill_en) begin
        fl++;
        if (fill_bit != fo || dcs_ce || !cs_ce || !scan_en) fbad++;
      end
      if (dcs_ce && cs_ce) both++;
      @(negedge clk);
      start = (cyc == 3);   // R12: strobe while busy
    end
    start = 1'b0;
    if (m == 0) begin
      exp_tot = (d + c + 1) + (c + 1) * (n - 1); exp_sd = d; exp_sc = c * n;
      exp_cd = 0; exp_fl = 0; tag = "R3";
    end else if (m == 1) begin
      exp_tot = (d + c + 1) * n; exp_sd = d * n; exp_sc = c * n;
      exp_cd = 0; exp_fl = 0; tag = "R4";
    end else begin
      exp_tot = (2 * d + c + 2) * n + c; exp_sd = 2 * d * n; exp_sc = c * (n + 1);
      exp_cd = n; exp_fl = c; tag = "R5";
    end
    chk(done == 1'b1, "R11 done reached", done, 1);
    chk(cyc == exp_tot, {tag, " cycles"}, cyc, exp_tot);
    chk(int'(cyc_count) == exp_tot, "R10 cyc_count at done", cyc_count, exp_tot);
    chk(phase == 3'd7, "R11 phase at done", phase, 7);
    chk(sd == exp_sd, {tag, " quiet shifts"}, sd, exp_sd);
    chk(sc == exp_sc, {tag, " care shifts"}, sc, exp_sc);
    chk(cc == n, {tag, " care captures"}, cc, n);
    if (multi) chk(cd == exp_cd, "R5 quiet captures", cd, exp_cd);
    else       chk(cd == 0, "R7 no quiet capture", cd, 0);
    if (multi) chk(ordbad == 0, "R6 capture order", ordbad, 0);
    chk(fl == exp_fl, "R8 flush length", fl, exp_fl);
    chk(fbad == 0, "R8 flush controls", fbad, 0);
    chk(both == 0, "R2 one enable", both, 0);
    chk(first_q, "R9 quiet first", first_q, 1);
    @(negedge clk);
    chk(!done && !busy && phase == 3'd0, "R11 return idle", {done, busy, phase}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && !busy && !done, "R11 reset state", phase, 0);
    chk(!dcs_ce && !cs_ce && !scan_en, "R2 idle enables off", {dcs_ce, cs_ce, scan_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    test_mode = 1'b0;
    #1;
    chk(!scan_en && dcs_ce && cs_ce, "R1 normal mode", {scan_en, dcs_ce, cs_ce}, 3);
    pat_count = 1; dcs_len = 2; cs_len = 2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && phase == 3'd0, "R12 start ignored in normal mode", busy, 0);
    chk(!scan_en && dcs_ce && cs_ce, "R1 normal mode held", {scan_en, dcs_ce, cs_ce}, 3);
    test_mode = 1'b1;
    for (int m = 0; m < 3; m++)
      for (int d = 1; d <= 3; d++)
        for (int c = 1; c <= 3; c++)
          for (int n = 1; n <= 3; n++)
            run_case(m, d, c, n, 1'((d + n) & 1));
    run_case(3, 2, 1, 2, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule